// File: doc/BRIEF.md
# Dual-Tone Cycle-Timing Detector

This block decides whether a valid pair of tones is present on two band-limited channels. Each channel receives the signed output of its own bandpass filter, one tuned to a low-group target frequency and the other to a high-group target. A channel qualifies its frequency without spectral analysis. It counts clock ticks across a programmable number of whole input cycles, where each cycle is bounded by rising zero crossings with hysteresis. It then checks that tick count against a programmable lower and upper limit.

While a channel measures, it also keeps the largest sample magnitude seen. An interval counts as a match only if the time lies inside the window and that peak exceeds a programmable amplitude threshold. A pair controller declares a tone pair while both channels match together. It reports this through a live status bit and a sticky, level-active interrupt, which the host clears by writing a one to a clear input.

As an example, with a 6.144 MHz tick clock, a 697 Hz tone timed over 10 cycles takes about 88,000 ticks. The default 18-bit tick limits cover this.

Top module: `tone_pair_detector`

Channel states: `CH_HUNT` waits for a first crossing and moves to `CH_TIME` on one. `CH_TIME` counts ticks. It stays in `CH_TIME` at each crossing, so intervals run back to back. It returns to `CH_HUNT` on timeout. Pair states: `PR_ABSENT` moves to `PR_PRESENT` when both channels match. `PR_PRESENT` returns to `PR_ABSENT` when either channel stops matching.

## Requirements
- R1: A crossing is a valid sample greater than +H that arrives after an earlier valid sample less than −H, where H is the hysteresis input. Samples with their valid strobe low are ignored, so a tone of peak magnitude H or less never produces a crossing.
- R2: The measured time is the number of clock edges from the crossing that opens an interval to the N-th crossing after it, where N is the channel's cycle count. An N of 0 behaves as 1. The crossing that closes an interval opens the next one.
- R3: At the closing crossing the channel passes only if the lower limit ≤ time ≤ the upper limit, with both limits inclusive.
- R4: If the tick count exceeds the upper limit before the interval closes, the channel match clears and the channel waits in `CH_HUNT` for a new crossing.
- R5: An interval passes only if the peak absolute sample value over the interval is strictly greater than the amplitude threshold.
- R6: A channel match changes only at the clock edge that takes a closing crossing, or at a timeout. It never rises without a valid sample on that edge.
- R7: `pair_present` is 1 exactly one clock after both channel matches are 1. It returns to 0 one clock after either match is 0.
- R8: `irq` sets at the same edge at which `pair_present` rises. It stays at 1 until a cycle with `irq_clr` high, and it clears at the next edge unless a new pair rises at that edge.
- R9: After reset, `chan_match`, `pair_present` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_valid | input | 1 | Low-group sample strobe |
| lo_sample | input | SW | Low-group signed sample |
| hi_valid | input | 1 | High-group sample strobe |
| hi_sample | input | SW | High-group signed sample |
| lo_cycles | input | CW | Low-group cycles per interval |
| hi_cycles | input | CW | High-group cycles per interval |
| lo_tmin | input | TW | Low-group lower tick limit |
| lo_tmax | input | TW | Low-group upper tick limit |
| hi_tmin | input | TW | High-group lower tick limit |
| hi_tmax | input | TW | High-group upper tick limit |
| hyst | input | SW-1 | Crossing hysteresis magnitude H |
| amp_thr | input | SW | Amplitude threshold (unsigned) |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| chan_match | output | 2 | Per-channel match, bit 0 low group, bit 1 high group |
| pair_present | output | 1 | Live tone-pair status |
| irq | output | 1 | Sticky interrupt request |

## Verification
Square-wave tones are applied with periods chosen so that the measured time lands exactly on, just inside or just outside each limit. This separates the inclusive window compare from the timeout path. Amplitudes equal to and one above the threshold and the hysteresis separate the strict compares. Tones with the strobe held low show that invalid samples are ignored. A one-sided tone, a tone that stops after a pair is declared, and a clear pulse during a live pair separate the live status from the sticky interrupt. Random periods, cycle counts, windows and amplitudes are checked against a bench model of the window and amplitude rules.

// File: rtl/tpd_pkg.sv
`timescale 1ns/1ps
package tpd_pkg;
    typedef enum logic {CH_HUNT, CH_TIME} ch_state_e;
    typedef enum logic {PR_ABSENT, PR_PRESENT} pair_state_e;
endpackage

// File: rtl/tpd_zero_cross.sv
`timescale 1ns/1ps
module tpd_zero_cross #(
    parameter int SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp,
    input  logic [SW-2:0]        hyst,
    output logic                 xing
);
    logic signed [SW-1:0] h_pos;
    logic signed [SW-1:0] h_neg;
    logic                 armed;

    assign h_pos = $signed({1'b0, hyst});
    assign h_neg = -h_pos;
    assign xing  = smp_valid && armed && (smp > h_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (smp_valid) begin
            if (smp < h_neg) begin
                armed <= 1'b1;
            end else if (xing) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tpd_chan_timer.sv
`timescale 1ns/1ps
module tpd_chan_timer
    import tpd_pkg::*;
#(
    parameter int SW = 12,
    parameter int CW = 5,
    parameter int TW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp,
    input  logic [SW-2:0]        hyst,
    input  logic [CW-1:0]        cycles,
    input  logic [TW-1:0]        t_min,
    input  logic [TW-1:0]        t_max,
    input  logic [SW-1:0]        amp_thr,
    output logic                 match
);
    localparam int TC = TW + 1;
    localparam int CX = CW + 1;

    ch_state_e     state, state_n;
    logic          xing;
    logic [TC-1:0] ticks;
    logic [TC-1:0] tick_inc;
    logic [TC-1:0] tmax_x;
    logic [CW-1:0] cyc;
    logic [SW-1:0] mag;
    logic [SW-1:0] peak;
    logic [SW-1:0] peak_upd;
    logic          last_cycle;
    logic          in_window;
    logic          loud;
    logic          timeout;

    tpd_zero_cross #(.SW(SW)) zc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp       (smp),
        .hyst      (hyst),
        .xing      (xing)
    );

    assign mag        = smp[SW-1] ? $unsigned(-smp) : $unsigned(smp);
    assign peak_upd   = (smp_valid && (mag > peak)) ? mag : peak;
    assign tmax_x     = {1'b0, t_max} + TC'(1);
    assign tick_inc   = (ticks >= tmax_x) ? ticks : ticks + TC'(1);
    assign last_cycle = ({1'b0, cyc} + CX'(1)) >= {1'b0, cycles};
    assign in_window  = (ticks >= {1'b0, t_min}) && (ticks <= {1'b0, t_max});
    assign loud       = peak > amp_thr;
    assign timeout    = ticks >= tmax_x;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_HUNT;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            CH_HUNT: if (xing) state_n = CH_TIME;
            CH_TIME: if (!xing && timeout) state_n = CH_HUNT;
            default: state_n = CH_HUNT;
        endcase
    end

    // measurement datapath and match output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks <= '0;
            cyc   <= '0;
            peak  <= '0;
            match <= 1'b0;
        end else begin
            unique case (state)
                CH_HUNT: begin
                    if (xing) begin
                        ticks <= TC'(1);
                        cyc   <= '0;
                        peak  <= mag;
                    end
                end
                CH_TIME: begin
                    if (xing && last_cycle) begin
                        match <= in_window && loud;
                        ticks <= TC'(1);
                        cyc   <= '0;
                        peak  <= mag;
                    end else if (xing) begin
                        cyc   <= cyc + CW'(1);
                        ticks <= tick_inc;
                        peak  <= peak_upd;
                    end else if (timeout) begin
                        match <= 1'b0;
                    end else begin
                        ticks <= tick_inc;
                        peak  <= peak_upd;
                    end
                end
                default: begin
                    match <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tpd_pair_ctl.sv
`timescale 1ns/1ps
module tpd_pair_ctl
    import tpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_a,
    input  logic match_b,
    input  logic irq_clr,
    output logic pair_present,
    output logic irq
);
    pair_state_e state, state_n;
    logic        both;

    assign both = match_a && match_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PR_ABSENT;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            PR_ABSENT:  if (both)  state_n = PR_PRESENT;
            PR_PRESENT: if (!both) state_n = PR_ABSENT;
            default:    state_n = PR_ABSENT;
        endcase
    end

    // outputs: live status and sticky request
    assign pair_present = (state == PR_PRESENT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (state == PR_ABSENT && both) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/tone_pair_detector.sv
`timescale 1ns/1ps
module tone_pair_detector #(
    parameter int SW = 12,
    parameter int CW = 5,
    parameter int TW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_valid,
    input  logic signed [SW-1:0] lo_sample,
    input  logic                 hi_valid,
    input  logic signed [SW-1:0] hi_sample,
    input  logic [CW-1:0]        lo_cycles,
    input  logic [CW-1:0]        hi_cycles,
    input  logic [TW-1:0]        lo_tmin,
    input  logic [TW-1:0]        lo_tmax,
    input  logic [TW-1:0]        hi_tmin,
    input  logic [TW-1:0]        hi_tmax,
    input  logic [SW-2:0]        hyst,
    input  logic [SW-1:0]        amp_thr,
    input  logic                 irq_clr,
    output logic [1:0]           chan_match,
    output logic                 pair_present,
    output logic                 irq
);
    localparam int NCH = 2;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tpd_chan_timer #(.SW(SW), .CW(CW), .TW(TW)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid ((g == 0) ? lo_valid  : hi_valid),
            .smp       ((g == 0) ? lo_sample : hi_sample),
            .hyst      (hyst),
            .cycles    ((g == 0) ? lo_cycles : hi_cycles),
            .t_min     ((g == 0) ? lo_tmin   : hi_tmin),
            .t_max     ((g == 0) ? lo_tmax   : hi_tmax),
            .amp_thr   (amp_thr),
            .match     (chan_match[g])
        );
    end

    tpd_pair_ctl pair_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .match_a      (chan_match[0]),
        .match_b      (chan_match[1]),
        .irq_clr      (irq_clr),
        .pair_present (pair_present),
        .irq          (irq)
    );
endmodule

// File: rtl/tpd_checker.sv
`timescale 1ns/1ps
module tpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       lo_valid,
    input logic       hi_valid,
    input logic       irq_clr,
    input logic [1:0] chan_match,
    input logic       pair_present,
    input logic       irq
);
    p_pair_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_present == $past(chan_match[0] && chan_match[1]));

    p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_present) |-> irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && pair_present) |=> !irq);

    p_lo_rise_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_match[0]) |-> $past(lo_valid));

    p_hi_rise_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_match[1]) |-> $past(hi_valid));
endmodule

bind tone_pair_detector tpd_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_valid     (lo_valid),
    .hi_valid     (hi_valid),
    .irq_clr      (irq_clr),
    .chan_match   (chan_match),
    .pair_present (pair_present),
    .irq          (irq)
);

// File: tb/tone_pair_detector_tb_top.sv
`timescale 1ns/1ps
module tone_pair_detector_tb_top;
    localparam int SW = 12;
    localparam int CW = 5;
    localparam int TW = 18;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 lo_valid = 1'b0, hi_valid = 1'b0;
    logic signed [SW-1:0] lo_sample = '0, hi_sample = '0;
    logic [CW-1:0]        lo_cycles = '0, hi_cycles = '0;
    logic [TW-1:0]        lo_tmin = '0, lo_tmax = '0, hi_tmin = '0, hi_tmax = '0;
    logic [SW-2:0]        hyst = '0;
    logic [SW-1:0]        amp_thr = '0;
    logic                 irq_clr = 1'b0;
    logic [1:0]           chan_match;
    logic                 pair_present;
    logic                 irq;

    int n_checks = 0;
    int n_fail   = 0;
    int per[2];
    int amp[2];
    int ph[2];
    bit on[2];
    bit vld[2];
    bit done = 0;

    tone_pair_detector #(.SW(SW), .CW(CW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lo_valid(lo_valid), .lo_sample(lo_sample),
        .hi_valid(hi_valid), .hi_sample(hi_sample),
        .lo_cycles(lo_cycles), .hi_cycles(hi_cycles),
        .lo_tmin(lo_tmin), .lo_tmax(lo_tmax),
        .hi_tmin(hi_tmin), .hi_tmax(hi_tmax),
        .hyst(hyst), .amp_thr(amp_thr), .irq_clr(irq_clr),
        .chan_match(chan_match), .pair_present(pair_present), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lo_valid  = vld[0];
            hi_valid  = vld[1];
            lo_sample = on[0] ? ((ph[0] < per[0] / 2) ? SW'(-amp[0]) : SW'(amp[0])) : '0;
            hi_sample = on[1] ? ((ph[1] < per[1] / 2) ? SW'(-amp[1]) : SW'(amp[1])) : '0;
            ph[0] = (ph[0] + 1) % per[0];
            ph[1] = (ph[1] + 1) % per[1];
        end
    endtask

    function automatic bit exp_match(input int p, input int n, input int tmin, input int tmax,
                                     input int a, input int thr, input int h, input bit v);
        int nn = (n == 0) ? 1 : n;
        int t  = nn * p;
        return v && (a > h) && (t >= tmin) && (t <= tmax) && (a > thr);
    endfunction

    task automatic setup(input int p0, input int n0, input int tmin0, input int tmax0, input int a0,
                         input int p1, input int n1, input int tmin1, input int tmax1, input int a1,
                         input int thr, input int h);
        per[0] = p0; per[1] = p1; amp[0] = a0; amp[1] = a1;
        ph[0] = 0; ph[1] = 0; on[0] = 1; on[1] = 1; vld[0] = 1; vld[1] = 1;
        lo_cycles = CW'(n0); hi_cycles = CW'(n1);
        lo_tmin = TW'(tmin0); lo_tmax = TW'(tmax0);
        hi_tmin = TW'(tmin1); hi_tmax = TW'(tmax1);
        amp_thr = SW'(thr); hyst = (SW-1)'(h);
    endtask

    task automatic start_trial();
        int l;
        @(negedge clk);
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        l = 6 * (per[0] * 32 > per[1] * 32 ? per[0] : per[1]) * (int'(lo_cycles) > int'(hi_cycles) ? int'(lo_cycles) + 1 : int'(hi_cycles) + 1)
            + int'(lo_tmax) + int'(hi_tmax) + 40;
        run(l);
    endtask

    task automatic check_all(input string req, input bit e0, input bit e1);
        chk(chan_match[0] == e0, {req, " low match"}, chan_match[0], e0);
        chk(chan_match[1] == e1, {req, " high match"}, chan_match[1], e1);
        chk(pair_present == (e0 && e1), {req, " pair"}, pair_present, e0 && e1);
        chk(irq == (e0 && e1), {req, " irq"}, irq, e0 && e1);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        run(1);
        irq_clr = 1'b0;
        run(1);
    endtask

    initial begin : watchdog
        int cnt = 0;
        while (!done) begin
            @(posedge clk);
            cnt++;
            if (cnt > 190000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cnt, 190000);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20251107));
        per[0] = 2; per[1] = 2; amp[0] = 0; amp[1] = 0;
        run(2);
        // R9: reset state
        chk(chan_match == 2'b00, "R9 match", chan_match, 0);
        chk(pair_present == 1'b0, "R9 pair", pair_present, 0);
        chk(irq == 1'b0, "R9 irq", irq, 0);
        rst_n = 1'b1;

        // R2 R3: nominal pair, low 20x4=80, high 12x6=72
        setup(20, 4, 70, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R2", 1, 1);

        // R3: inclusive lower limit exactly 80, then 81
        setup(20, 4, 80, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R3", 1, 1);
        setup(20, 4, 81, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R3", 0, 1);

        // R3 R4: upper limit exactly 72, then 71 (timeout path)
        setup(20, 4, 70, 90, 500, 12, 6, 60, 72, 400, 100, 8);
        start_trial();
        check_all("R3", 1, 1);
        setup(20, 4, 70, 90, 500, 12, 6, 60, 71, 400, 100, 8);
        start_trial();
        check_all("R4", 1, 0);

        // R5: amplitude equal to threshold fails, one above passes
        setup(20, 4, 70, 90, 100, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R5", 0, 1);
        setup(20, 4, 70, 90, 101, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R5", 1, 1);

        // R1: magnitude equal to hysteresis never crosses, one above does
        setup(20, 4, 70, 90, 8, 12, 6, 60, 80, 400, 2, 8);
        start_trial();
        check_all("R1", 0, 1);
        setup(20, 4, 70, 90, 9, 12, 6, 60, 80, 400, 2, 8);
        start_trial();
        check_all("R1", 1, 1);

        // R1: strobe low, samples ignored on the high channel
        setup(20, 4, 70, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        vld[1] = 0;
        start_trial();
        check_all("R1", 1, 0);

        // R2: cycle count 0 acts as 1
        setup(20, 0, 18, 22, 500, 12, 1, 10, 14, 400, 100, 8);
        start_trial();
        check_all("R2", 1, 1);

        // R8 R6 R4 R7: clear while live, then stop a tone
        setup(20, 4, 70, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        check_all("R8", 1, 1);
        pulse_clr();
        chk(irq == 1'b0, "R8 cleared", irq, 0);
        chk(pair_present == 1'b1, "R8 pair kept", pair_present, 1);
        run(200);
        chk(irq == 1'b0, "R8 no re-arm", irq, 0);
        setup(20, 4, 70, 90, 500, 12, 6, 60, 80, 400, 100, 8);
        start_trial();
        on[0] = 0;
        run(5);
        chk(chan_match[0] == 1'b1, "R6 hold", chan_match[0], 1);
        run(200);
        chk(chan_match[0] == 1'b0, "R4 timeout", chan_match[0], 0);
        chk(pair_present == 1'b0, "R7 drop", pair_present, 0);
        chk(irq == 1'b1, "R8 sticky", irq, 1);
        pulse_clr();
        chk(irq == 1'b0, "R8 clear", irq, 0);

        // random trials against the window and amplitude model
        for (int k = 0; k < 16; k++) begin
            int p[2], n[2], tmn[2], tmx[2], a[2], thr, d;
            bit e[2];
            thr = 50 + int'($urandom_range(0, 400));
            for (int c = 0; c < 2; c++) begin
                p[c]   = 6 + int'($urandom_range(0, 34));
                n[c]   = 1 + int'($urandom_range(0, 5));
                d      = int'($urandom_range(0, 30)) - 15;
                tmn[c] = n[c] * p[c] + d;
                if (tmn[c] < 0) tmn[c] = 0;
                tmx[c] = tmn[c] + int'($urandom_range(0, 30));
                a[c]   = thr - 20 + int'($urandom_range(0, 200));
                e[c]   = exp_match(p[c], n[c], tmn[c], tmx[c], a[c], thr, 8, 1);
            end
            setup(p[0], n[0], tmn[0], tmx[0], a[0], p[1], n[1], tmn[1], tmx[1], a[1], thr, 8);
            start_trial();
            check_all("R3 R5 random", e[0], e[1]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule